// File: doc/BRIEF.md
# Instruction Fetch and Skip Sequencer

This block is the front end of a small 4-bit controller core. It reads program bytes from a synchronous byte-wide program store and assembles them into whole instructions. Most opcodes are a single byte. A small set of opcodes carries a second byte, and the sequencer reads that byte from the following address and attaches it as the parameter. One machine cycle is two input clocks. Each byte read uses exactly one machine cycle. The program counter moves forward inside the current 64-byte page after every byte.

Finished instructions leave through a one-entry valid/ready output slot. When `ins_valid` is high and `ins_ready` is low, the slot keeps every output field steady and no new opcode read begins. A new instruction can start only while the slot is empty or is being accepted in the same clock, so the slot is never overwritten. If the downstream stage sets `skip_set` during a handshake, the instruction delivered next still has its bytes read in full. It comes out as a no-operation, with the execute enable low. The sequencer also reports the opcode of the instruction delivered before the current one, which later stages use as a prefix modifier, and a free-running count of completed machine cycles.

Top module: `fetch_skip_seq`

## Requirements
- R1: While reset is held and on release, `ins_valid` is 0, `ins_opcode`, `ins_prev` and `cycle_count` are 0, and the first read is at address 0xDC0 (page field 3, middle field 7, low field 0; address = page<<10 | middle<<6 | low).
- R2: Each byte read takes one machine cycle of two clocks. `mem_rd` is high only in the first clock of a machine cycle, so it is never high in two consecutive clocks, and the byte is taken from `mem_rdata` in the second clock.
- R3: Opcode 0x5F and opcodes 0x70 to 0x7F are two bytes long. Their parameter is the byte at the next address. A one-byte instruction shows `ins_param` = 0x00.
- R4: After every byte read, the low 6 address bits go up by one modulo 64, and the upper 6 bits do not change.
- R5: `skip_set` is taken only in a clock where `ins_valid` and `ins_ready` are both high, and it is ignored in any other clock. When taken, the next delivered instruction has all its bytes read but shows opcode 0x00, parameter 0x00 and `ins_exec` = 0.
- R6: The skip flag covers one instruction only. The instruction after a skipped one has `ins_exec` = 1 unless a new skip was taken.
- R7: `ins_prev` shows the opcode of the previously delivered instruction as it was delivered (0x00 if that one was skipped), and 0x00 for the first instruction after reset.
- R8: While `ins_valid` is high and `ins_ready` is low, all outputs of the slot stay stable and `mem_rd` stays low.
- R9: `cycle_count` goes up by one after each completed byte read, wraps at its width, and does not change otherwise.
- R10: With `ins_ready` held high, an instruction of L bytes is offered 2·L clocks after the previous handshake, or 2·L clocks after reset release for the first instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per machine cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Program store read strobe |
| mem_addr | output | 12 | Program store byte address |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |
| skip_set | input | 1 | Skip the next instruction; taken only on a handshake |
| ins_valid | output | 1 | Output slot holds an instruction |
| ins_ready | input | 1 | Downstream accepts the slot |
| ins_opcode | output | 8 | Delivered opcode (0x00 when skipped) |
| ins_param | output | 8 | Parameter byte (0x00 for one-byte or skipped) |
| ins_prev | output | 8 | Opcode of the previously delivered instruction |
| ins_exec | output | 1 | Execute enable, low for a skipped instruction |
| cycle_count | output | 16 | Completed machine cycles, wrapping |

## Verification
The hardest case to reach from the ports is a skipped two-byte instruction that sits in the slot while `ins_ready` is low, with `skip_set` toggling in the stalled clocks that must be ignored. The stimulus runs a program image that mixes 0x5F and 0x7x opcodes. One of them is placed at the last byte of the page, so its parameter comes from the wrapped address. The stimulus then drives `ins_ready` and `skip_set` from a pseudo-random source, so stalls, skips, skips of long instructions and back-to-back skips all occur. A second reset in the middle of a stream checks that the skip flag and the previous-opcode state clear.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [0:0] {
    FS_OPC = 1'b0,
    FS_PRM = 1'b1
  } fs_state_e;

  localparam logic [OPC_W-1:0] OP_NOP      = 8'h00;
  localparam logic [OPC_W-1:0] OP_LONG_ONE = 8'h5F;
  localparam logic [3:0]       OP_LONG_GRP = 4'h7;

  function automatic logic is_two_byte(input logic [OPC_W-1:0] op);
    return (op == OP_LONG_ONE) || (op[7:4] == OP_LONG_GRP);
  endfunction

endpackage

// File: rtl/fsq_timer.sv
module fsq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             phase,
  output logic             byte_done,
  output logic [CNT_W-1:0] cyc_count
);

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (go) phase_q <= ~phase_q;
      if (phase_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase     = phase_q;
  assign byte_done = phase_q;
  assign cyc_count = cnt_q;

  // the second half of a machine cycle always finishes
  p_phase_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> !phase_q);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(cnt_q));

endmodule

// File: rtl/fsq_pc.sv
module fsq_pc #(
  parameter int PU_W   = 2,
  parameter int PM_W   = 4,
  parameter int PL_W   = 6,
  parameter int RST_PU = 3,
  parameter int RST_PM = 7,
  parameter int RST_PL = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     advance,
  output logic [PU_W+PM_W+PL_W-1:0] pc
);

  localparam int PC_W   = PU_W + PM_W + PL_W;
  localparam int PAGE_W = PU_W + PM_W;

  typedef logic [PL_W-1:0]   low_t;
  typedef logic [PAGE_W-1:0] page_t;

  localparam logic [PC_W-1:0] PC_ENTRY =
    {PU_W'(RST_PU), PM_W'(RST_PM), PL_W'(RST_PL)};

  page_t page_q;
  low_t  low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= PC_ENTRY[PC_W-1:PL_W];
      low_q  <= PC_ENTRY[PL_W-1:0];
    end else if (advance) begin
      low_q <= low_t'(low_q + 1'b1);
    end
  end

  assign pc = {page_q, low_q};

  p_page_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc[PC_W-1:PL_W] == $past(pc[PC_W-1:PL_W]));

  p_low_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc[PL_W-1:0] == low_t'($past(pc[PL_W-1:0]) + 1'b1));

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc));

endmodule

// File: rtl/fsq_slot.sv
module fsq_slot #(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] new_op,
  input  logic [OW-1:0] new_param,
  input  logic          out_ready,
  input  logic          skip_set,
  output logic          out_valid,
  output logic [OW-1:0] out_op,
  output logic [OW-1:0] out_param,
  output logic [OW-1:0] out_prev,
  output logic          out_exec
);

  logic          valid_q;
  logic          skip_q;
  logic          exec_q;
  logic [OW-1:0] op_q;
  logic [OW-1:0] param_q;
  logic [OW-1:0] prev_q;
  logic          hs;

  assign hs = valid_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exec_q  <= 1'b0;
      op_q    <= '0;
      param_q <= '0;
      prev_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      prev_q  <= op_q;
      exec_q  <= ~skip_q;
      op_q    <= skip_q ? '0 : new_op;
      param_q <= skip_q ? '0 : new_param;
    end else if (hs) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               skip_q <= 1'b0;
    else if (hs && skip_set)  skip_q <= 1'b1;
    else if (load)            skip_q <= 1'b0;
  end

  assign out_valid = valid_q;
  assign out_op    = op_q;
  assign out_param = param_q;
  assign out_prev  = prev_q;
  assign out_exec  = exec_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(op_q) && $stable(param_q)
                                 && $stable(prev_q) && $stable(exec_q)));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);

  p_prev_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> prev_q == $past(op_q));

  p_skip_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !exec_q) |-> (op_q == '0 && param_q == '0));

  p_skip_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_q) && !exec_q) |-> !skip_q);

endmodule

// File: rtl/fetch_skip_seq.sv
module fetch_skip_seq #(
  parameter int PU_W   = 2,
  parameter int PM_W   = 4,
  parameter int PL_W   = 6,
  parameter int RST_PU = 3,
  parameter int RST_PM = 7,
  parameter int RST_PL = 0,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic                      mem_rd,
  output logic [PU_W+PM_W+PL_W-1:0] mem_addr,
  input  logic [7:0]                mem_rdata,
  input  logic                      skip_set,
  output logic                      ins_valid,
  input  logic                      ins_ready,
  output logic [7:0]                ins_opcode,
  output logic [7:0]                ins_param,
  output logic [7:0]                ins_prev,
  output logic                      ins_exec,
  output logic [CNT_W-1:0]          cycle_count
);
  import fsq_pkg::*;

  localparam int PC_W = PU_W + PM_W + PL_W;

  fs_state_e        state_q;
  logic [OPC_W-1:0] op_hold_q;
  logic             phase;
  logic             byte_done;
  logic             can_start;
  logic             go;
  logic             load;
  logic             long_op;
  logic [OPC_W-1:0] load_op;
  logic [OPC_W-1:0] load_param;
  logic [PC_W-1:0]  pc;

  // an opcode read may begin only when the slot is empty or draining now
  assign can_start = !ins_valid || ins_ready;
  assign go        = phase ? 1'b1 : ((state_q == FS_PRM) || can_start);
  assign mem_rd    = !phase && go;
  assign mem_addr  = pc;

  assign long_op    = is_two_byte(mem_rdata);
  assign load       = byte_done && ((state_q == FS_PRM) || !long_op);
  assign load_op    = (state_q == FS_PRM) ? op_hold_q : mem_rdata;
  assign load_param = (state_q == FS_PRM) ? mem_rdata : OP_NOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= FS_OPC;
      op_hold_q <= OP_NOP;
    end else if (byte_done) begin
      if (state_q == FS_OPC) begin
        op_hold_q <= mem_rdata;
        if (long_op) state_q <= FS_PRM;
      end else begin
        state_q <= FS_OPC;
      end
    end
  end

  fsq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .phase     (phase),
    .byte_done (byte_done),
    .cyc_count (cycle_count)
  );

  fsq_pc #(
    .PU_W(PU_W), .PM_W(PM_W), .PL_W(PL_W),
    .RST_PU(RST_PU), .RST_PM(RST_PM), .RST_PL(RST_PL)
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (byte_done),
    .pc      (pc)
  );

  fsq_slot #(.OW(OPC_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .new_op    (load_op),
    .new_param (load_param),
    .out_ready (ins_ready),
    .skip_set  (skip_set),
    .out_valid (ins_valid),
    .out_op    (ins_opcode),
    .out_param (ins_param),
    .out_prev  (ins_prev),
    .out_exec  (ins_exec)
  );

  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_stall_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |-> !mem_rd);

  p_param_after_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state_q == FS_OPC && long_op) |=> (!load && mem_rd == !phase));

endmodule

// File: tb/fetch_skip_seq_bench.sv
module fetch_skip_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        skip_set = 1'b0;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [7:0]  ins_opcode;
  logic [7:0]  ins_param;
  logic [7:0]  ins_prev;
  logic        ins_exec;
  logic [15:0] cycle_count;

  int total = 0;
  int bad   = 0;
  logic [7:0] bmem [64];

  always #10 clk = ~clk;

  fetch_skip_seq u_fetch_skip_seq (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .skip_set(skip_set), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_opcode(ins_opcode), .ins_param(ins_param),
    .ins_prev(ins_prev), .ins_exec(ins_exec), .cycle_count(cycle_count)
  );

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= bmem[mem_addr[5:0]];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit long_op(input logic [7:0] op);
    return (op == 8'h5F) || (op[7:4] == 4'h7);
  endfunction

  // mode 0: ready held high, no skips; mode 1: random ready and skip
  task automatic run(input int n_instr, input int mode);
    logic [5:0]  fptr = 6'd0;
    logic [5:0]  mptr = 6'd0;
    int          reads = 0;
    int          lag1 = 0;
    bit          prev_rd = 0;
    bit          pend_skip = 0;
    bit          last_skipped = 0;
    logic [7:0]  last_op = 8'h00;
    int          clk_idx = 0;
    int          last_hs = 0;
    int          done = 0;
    rst_n = 1'b0;
    skip_set = 1'b0;
    ins_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R1 valid in reset", ins_valid, 0);
      chk("R1 count in reset", cycle_count, 0);
      chk("R1 prev in reset", ins_prev, 0);
      chk("R1 opcode in reset", ins_opcode, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    while (done < n_instr) begin
      if (clk_idx != 0) @(negedge clk);
      if (mode == 0) begin
        ins_ready = 1'b1;
        skip_set  = 1'b0;
      end else begin
        ins_ready = ($urandom % 3) != 0;
        skip_set  = ($urandom % 3) == 0;
      end
      #1;
      // read address and timing
      if (mem_rd) begin
        chk(reads == 0 ? "R1 entry address" : "R4 read address",
            mem_addr, {6'h37, fptr});
        fptr = fptr + 6'd1;
      end
      if (prev_rd && mem_rd) chk("R2 back-to-back read", 1, 0);
      chk("R9 cycle count", cycle_count, lag1[15:0]);
      lag1 = reads;
      if (mem_rd) reads++;
      prev_rd = mem_rd;
      if (ins_valid && !ins_ready) chk("R8 read while stalled", mem_rd, 0);
      if (ins_valid && ins_ready) begin
        logic [7:0] eop;
        logic [7:0] epar;
        int         len;
        eop  = bmem[mptr];
        mptr = mptr + 6'd1;
        epar = 8'h00;
        len  = 1;
        if (long_op(eop)) begin
          epar = bmem[mptr];
          mptr = mptr + 6'd1;
          len  = 2;
        end
        if (mode == 0) chk("R10 delivery spacing", clk_idx - last_hs, 2 * len);
        last_hs = clk_idx;
        if (pend_skip) begin
          chk("R5 skipped opcode", ins_opcode, 0);
          chk("R5 skipped param", ins_param, 0);
          chk("R5 skipped exec", ins_exec, 0);
          eop = 8'h00;
        end else begin
          chk("R3 opcode", ins_opcode, eop);
          chk("R3 param", ins_param, epar);
          chk(last_skipped ? "R6 exec after skip" : "R5 exec", ins_exec, 1);
        end
        chk("R7 previous opcode", ins_prev, last_op);
        last_skipped = pend_skip;
        last_op = eop;
        pend_skip = skip_set;
        done++;
      end
      clk_idx++;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = 8'((i * 37 + 11) & 8'hFF);
    bmem[0]  = 8'h5F;
    bmem[1]  = 8'h21;
    bmem[2]  = 8'h7C;
    bmem[3]  = 8'h9A;
    bmem[4]  = 8'h02;
    bmem[20] = 8'h70;
    bmem[40] = 8'h5F;
    bmem[63] = 8'h7A;
    run(60, 0);
    run(250, 1);
    run(30, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule